// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block receives asynchronous serial characters on a single input line. It takes a sampling strobe that pulses sixteen times per bit period. It finds each start bit and checks it at mid-bit. It then reads the data bits and any extra bit at the centre of each bit period, and checks the stop bit or bits. Each finished character goes into a 64-entry first-in first-out queue. A consumer drains the queue through a show-ahead read port. A fill count, a full flag and a data-ready flag show the queue's state to the consumer.

Four sticky error indications tell the consumer about line problems. They cover a bad stop bit, a parity mismatch, a character lost because the queue was full, and a break condition, where the line is held low for a whole frame. Each indication stays set until its own clear bit is pulsed. The frame format is set by static inputs: 7 or 8 data bits, an optional parity bit (even or odd) or an optional multiprocessor marker bit, and one or two stop bits.

Top module: `serial_rx_core`

## Requirements
- R1: A low level seen on a sampling strobe starts a start bit. The line is sampled again on the eighth strobe after that. If the line is high there, the edge is dropped as a glitch, no character is produced, and the receiver goes back to hunting for a start bit.
- R2: Each data bit is taken on the sixteenth strobe after the previous sample, at mid-bit. Bits are assembled least significant first. In 7-bit mode, bit 7 of the read data is 0.
- R3: When parity is enabled, the parity bit follows the data. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number. A mismatch sets the parity error flag.
- R4: When the marker bit is enabled and parity is not, the bit after the data is stored with the character and shown on the marker output. When both are enabled, that bit is treated as parity and the stored marker is 0.
- R5: One or two stop bits are expected. A stop bit sampled low sets the framing error flag. The character is still stored.
- R6: A frame read as all zeros up to and including the first stop bit is a break. It sets the break flag, does not set the framing error flag and stores nothing. The receiver then waits for the line to return high before it hunts for a new start bit.
- R7: The queue holds 64 characters in arrival order. The read port shows the oldest one. A read pulse removes it, and a read pulse while the queue is empty is ignored. The fill count gives the number of stored characters.
- R8: Data-ready is high exactly when the fill count is non-zero. Full is high exactly when the fill count is 64.
- R9: A character that completes while the queue is full is discarded and sets the overrun flag. The queue contents and the fill count are left unchanged.
- R10: All four error flags are sticky. Clear bit 0 clears framing, bit 1 parity, bit 2 overrun and bit 3 break. A new error in the same cycle as its clear leaves the flag set.
- R11: After reset, the fill count is 0, data-ready and full are low and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Sampling strobe, 16 pulses per bit period |
| len7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en_i | input | 1 | Enables a parity bit after the data |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| mp_en_i | input | 1 | Enables the marker bit (used when parity is off) |
| stop2_i | input | 1 | 1 selects two stop bits |
| rd_en_i | input | 1 | Removes the oldest queued character |
| rd_data_o | output | 8 | Oldest queued character |
| rd_mpb_o | output | 1 | Marker bit of the oldest queued character |
| fill_o | output | 7 | Number of queued characters |
| ready_o | output | 1 | Queue not empty |
| full_o | output | 1 | Queue holds 64 characters |
| ferr_o | output | 1 | Sticky framing error |
| perr_o | output | 1 | Sticky parity error |
| orun_o | output | 1 | Sticky overrun error |
| brk_o | output | 1 | Sticky break detected |
| clr_i | input | 4 | Flag clears: bit 0 framing, 1 parity, 2 overrun, 3 break |

## Verification
The checker watches several properties on every cycle. Data-ready and full stay consistent with the fill count. The count moves by at most one per cycle and never exceeds the depth. The four error flags stay sticky. A break or an overrun never changes the fill count. The bench scenarios cover what timing and data alone can show: the mid-bit sampling points, glitch rejection, the assembled bit order in both data lengths, parity in both senses, marker handling, stop-bit checking, the return from a break, and the order in which a full queue drains. These are compared against a behavioural tick-level model on every clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_BITS,
      RX_STOP,
      RX_HOLD
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       mpb;
   } rx_char_t;

   typedef struct packed {
      logic brk;
      logic orun;
      logic perr;
      logic ferr;
   } rx_flags_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= din;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign dout = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick_i,
   input  logic     line_i,
   input  logic     len7_i,
   input  logic     par_en_i,
   input  logic     par_odd_i,
   input  logic     mp_en_i,
   input  logic     stop2_i,
   output logic     done_o,
   output rx_char_t char_o,
   output logic     perr_o,
   output logic     ferr_o,
   output logic     brk_o
);
   localparam int CW   = $clog2(OVERSAMPLE);
   localparam int HALF = OVERSAMPLE / 2;
   localparam int FBW  = 9;
   localparam int IW   = 4;

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [IW-1:0]    bidx;
   logic             stop_idx;
   logic [FBW-1:0]   fb;

   logic             last_tick;
   logic             half_tick;
   logic [IW-1:0]    nbits;
   logic [7:0]       data_w;
   logic             extra_w;
   logic             sample_stop;
   logic             all_zero;

   always_comb begin
      last_tick   = (cnt == CW'(OVERSAMPLE - 1));
      half_tick   = (cnt == CW'(HALF - 1));
      nbits       = (len7_i ? IW'(7) : IW'(8)) + ((par_en_i || mp_en_i) ? IW'(1) : IW'(0));
      data_w      = len7_i ? {1'b0, fb[6:0]} : fb[7:0];
      extra_w     = len7_i ? fb[7] : fb[8];
      all_zero    = (fb == '0);
      sample_stop = tick_i && (state == RX_STOP) && last_tick;
      brk_o       = sample_stop && !stop_idx && !line_i && all_zero;
      done_o      = sample_stop &&
                    (stop_idx || (line_i ? !stop2_i : !all_zero));
      ferr_o      = done_o && !line_i;
      perr_o      = done_o && par_en_i && ((^data_w ^ extra_w) != par_odd_i);
      char_o.data = data_w;
      char_o.mpb  = mp_en_i && !par_en_i && extra_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         stop_idx <= 1'b0;
         fb       <= '0;
      end else if (tick_i) begin
         case (state)
            RX_IDLE: begin
               if (!line_i) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (half_tick) begin
                  if (line_i) begin
                     state <= RX_IDLE;
                  end else begin
                     state <= RX_BITS;
                     cnt   <= '0;
                     bidx  <= '0;
                     fb    <= '0;
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            RX_BITS: begin
               if (last_tick) begin
                  fb[bidx] <= line_i;
                  cnt      <= '0;
                  if (bidx == nbits - IW'(1)) begin
                     state    <= RX_STOP;
                     stop_idx <= 1'b0;
                  end else begin
                     bidx <= bidx + IW'(1);
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            RX_STOP: begin
               if (last_tick) begin
                  cnt <= '0;
                  if (brk_o) begin
                     state <= RX_HOLD;
                  end else if (done_o) begin
                     state <= RX_IDLE;
                  end else begin
                     stop_idx <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            RX_HOLD: begin
               if (line_i) begin
                  state <= RX_IDLE;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic [$clog2(DEPTH):0] count_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wptr;
   logic [AW:0]      rptr;

   always_ff @(posedge clk) begin
      if (push_i) begin
         mem[wptr[AW-1:0]] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push_i) wptr <= wptr + (AW+1)'(1);
         if (pop_i)  rptr <= rptr + (AW+1)'(1);
      end
   end

   assign count_o = wptr - rptr;
   assign full_o  = (count_o == (AW+1)'(DEPTH));
   assign empty_o = (count_o == '0);
   assign rdata_o = mem[rptr[AW-1:0]];
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int FIFO_DEPTH  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_i,
   input  logic                        tick_i,
   input  logic                        len7_i,
   input  logic                        par_en_i,
   input  logic                        par_odd_i,
   input  logic                        mp_en_i,
   input  logic                        stop2_i,
   input  logic                        rd_en_i,
   output logic [7:0]                  rd_data_o,
   output logic                        rd_mpb_o,
   output logic [$clog2(FIFO_DEPTH):0] fill_o,
   output logic                        ready_o,
   output logic                        full_o,
   output logic                        ferr_o,
   output logic                        perr_o,
   output logic                        orun_o,
   output logic                        brk_o,
   input  logic [3:0]                  clr_i
);
   localparam int CHW = $bits(rx_char_t);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two, at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic      line;
   logic      done;
   rx_char_t  chr;
   rx_char_t  head;
   logic      c_perr;
   logic      c_ferr;
   logic      c_brk;
   logic      q_full;
   logic      q_empty;
   logic      push;
   logic      pop;
   rx_flags_t flags_q;
   rx_flags_t set_v;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_i),
      .dout  (line)
   );

   srx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .line_i    (line),
      .len7_i    (len7_i),
      .par_en_i  (par_en_i),
      .par_odd_i (par_odd_i),
      .mp_en_i   (mp_en_i),
      .stop2_i   (stop2_i),
      .done_o    (done),
      .char_o    (chr),
      .perr_o    (c_perr),
      .ferr_o    (c_ferr),
      .brk_o     (c_brk)
   );

   assign push = done && !q_full;
   assign pop  = rd_en_i && !q_empty;

   srx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .wdata_i (chr),
      .pop_i   (pop),
      .rdata_o (head),
      .count_o (fill_o),
      .full_o  (q_full),
      .empty_o (q_empty)
   );

   always_comb begin
      set_v.ferr = c_ferr;
      set_v.perr = c_perr;
      set_v.orun = done && q_full;
      set_v.brk  = c_brk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         flags_q <= (flags_q & ~rx_flags_t'(clr_i)) | set_v;
      end
   end

   assign rd_data_o = head.data;
   assign rd_mpb_o  = head.mpb;
   assign ready_o   = !q_empty;
   assign full_o    = q_full;
   assign ferr_o    = flags_q.ferr;
   assign perr_o    = flags_q.perr;
   assign orun_o    = flags_q.orun;
   assign brk_o     = flags_q.brk;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int FIFO_DEPTH = 64
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rd_en_i,
   input logic [3:0]                  clr_i,
   input logic [$clog2(FIFO_DEPTH):0] fill_o,
   input logic                        ready_o,
   input logic                        full_o,
   input logic                        ferr_o,
   input logic                        perr_o,
   input logic                        orun_o,
   input logic                        brk_o
);
   localparam int FW = $clog2(FIFO_DEPTH) + 1;

   p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_o <= FW'(FIFO_DEPTH));

   p_fill_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_o == $past(fill_o)) || (fill_o == $past(fill_o) + FW'(1)) ||
      (fill_o + FW'(1) == $past(fill_o)));

   p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o == (fill_o != '0));

   p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full_o == (fill_o == FW'(FIFO_DEPTH)));

   p_brk_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_o) && !$past(rd_en_i) |-> fill_o == $past(fill_o));

   p_orun_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(orun_o) && !$past(rd_en_i) |-> fill_o == $past(fill_o));

   p_ferr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ferr_o) && !$past(clr_i[0]) |-> ferr_o);

   p_perr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(perr_o) && !$past(clr_i[1]) |-> perr_o);

   p_orun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(orun_o) && !$past(clr_i[2]) |-> orun_o);

   p_brk_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(brk_o) && !$past(clr_i[3]) |-> brk_o);
endmodule

bind serial_rx_core srx_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_srx_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en_i (rd_en_i),
   .clr_i   (clr_i),
   .fill_o  (fill_o),
   .ready_o (ready_o),
   .full_o  (full_o),
   .ferr_o  (ferr_o),
   .perr_o  (perr_o),
   .orun_o  (orun_o),
   .brk_o   (brk_o)
);

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
   localparam int DEPTH = 64;
   localparam int BITCLK = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_i = 1'b1;
   logic       tick_i = 1'b0;
   logic       len7_i = 1'b0;
   logic       par_en_i = 1'b0;
   logic       par_odd_i = 1'b0;
   logic       mp_en_i = 1'b0;
   logic       stop2_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [3:0] clr_i = 4'b0;
   logic [7:0] rd_data_o;
   logic       rd_mpb_o;
   logic [6:0] fill_o;
   logic       ready_o, full_o, ferr_o, perr_o, orun_o, brk_o;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   serial_rx_core u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
      .len7_i(len7_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
      .mp_en_i(mp_en_i), .stop2_i(stop2_i), .rd_en_i(rd_en_i),
      .rd_data_o(rd_data_o), .rd_mpb_o(rd_mpb_o), .fill_o(fill_o),
      .ready_o(ready_o), .full_o(full_o), .ferr_o(ferr_o), .perr_o(perr_o),
      .orun_o(orun_o), .brk_o(brk_o), .clr_i(clr_i)
   );

   // strobe: one pulse every 4 clocks, driven away from the active edge
   int phase = 0;
   always @(negedge clk) begin
      tick_i <= (phase == 3);
      phase  <= (phase + 1) % 4;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [8:0] mq[$];
   logic [3:0] mflags;
   logic       ms1, ms2;
   int         mst, mcnt, mbi, msi;
   logic [8:0] mfb;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         mflags = 4'b0;
         ms1 = 1'b1; ms2 = 1'b1;
         mst = 0; mcnt = 0; mbi = 0; msi = 0; mfb = 9'b0;
      end else begin
         logic line, done, ferr_ev, perr_ev, brk_ev, full_pre, extra, mpb;
         logic [7:0] dat;
         int nb;
         line = ms2; done = 0; ferr_ev = 0; perr_ev = 0; brk_ev = 0;
         nb = (len7_i ? 7 : 8) + ((par_en_i || mp_en_i) ? 1 : 0);
         if (tick_i) begin
            case (mst)
               0: if (!line) begin mst = 1; mcnt = 0; end
               1: if (mcnt == 7) begin
                     if (line) mst = 0;
                     else begin mst = 2; mcnt = 0; mbi = 0; mfb = 9'b0; end
                  end else mcnt++;
               2: if (mcnt == 15) begin
                     mfb[mbi] = line; mcnt = 0;
                     if (mbi == nb - 1) begin mst = 3; msi = 0; end else mbi++;
                  end else mcnt++;
               3: if (mcnt == 15) begin
                     mcnt = 0;
                     if (msi == 0) begin
                        if (!line) begin
                           if (mfb == 9'b0) begin brk_ev = 1; mst = 4; end
                           else begin done = 1; ferr_ev = 1; mst = 0; end
                        end else if (stop2_i) msi = 1;
                        else begin done = 1; mst = 0; end
                     end else begin
                        done = 1; ferr_ev = !line; mst = 0;
                     end
                  end else mcnt++;
               default: if (line) mst = 0;
            endcase
         end
         dat   = len7_i ? {1'b0, mfb[6:0]} : mfb[7:0];
         extra = len7_i ? mfb[7] : mfb[8];
         mpb   = mp_en_i && !par_en_i && extra;
         if (done && par_en_i && ((^dat ^ extra) != par_odd_i)) perr_ev = 1;
         full_pre = (mq.size() == DEPTH);
         if (rd_en_i && mq.size() > 0) void'(mq.pop_front());
         if (done && !full_pre) mq.push_back({dat, mpb});
         mflags = (mflags & ~clr_i) | {brk_ev, done && full_pre, perr_ev, ferr_ev};
         ms2 = ms1; ms1 = rx_i;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(fill_o == 7'(mq.size()) && ready_o == (mq.size() != 0) &&
               full_o == (mq.size() == DEPTH), "R7/R8 model fill", fill_o, mq.size());
         check({brk_o, orun_o, perr_o, ferr_o} == mflags, "R10 model flags",
               {brk_o, orun_o, perr_o, ferr_o}, mflags);
         if (mq.size() > 0)
            check({rd_data_o, rd_mpb_o} == mq[0], "R2 model head",
                  {rd_data_o, rd_mpb_o}, mq[0]);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic hold(input logic v, input int clocks);
      rx_i = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int dlen, input bit has_x,
                       input logic x, input logic s1, input logic s2, input bit two);
      hold(1'b0, BITCLK);
      for (int i = 0; i < dlen; i++) hold(d[i], BITCLK);
      if (has_x) hold(x, BITCLK);
      hold(s1, BITCLK);
      if (two) hold(s2, BITCLK);
      hold(1'b1, BITCLK);
   endtask

   task automatic pop1();
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear(input logic [3:0] m);
      clr_i = m;
      @(negedge clk);
      clr_i = 4'b0;
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   // ---------------- directed scenarios ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fill_o == 0 && !ready_o && !full_o, "R11 reset queue", fill_o, 0);
      check({brk_o, orun_o, perr_o, ferr_o} == 0, "R11 reset flags",
            {brk_o, orun_o, perr_o, ferr_o}, 0);
      hold(1'b1, 100);

      // R2: 8 data bits, one stop
      send(8'hA5, 8, 0, 0, 1, 1, 0);
      check(fill_o == 1 && rd_data_o == 8'hA5, "R2 8-bit char", rd_data_o, 8'hA5);
      check(ready_o, "R8 ready with data", ready_o, 1);
      pop1();

      // R1: short low pulse rejected
      hold(1'b0, 16);
      hold(1'b1, 300);
      check(fill_o == 0, "R1 glitch rejected", fill_o, 0);

      // R2: 7-bit mode
      len7_i = 1'b1;
      send(8'hD3, 7, 0, 0, 1, 1, 0);
      check(rd_data_o == 8'h53, "R2 7-bit char", rd_data_o, 8'h53);
      pop1();
      len7_i = 1'b0;

      // R3: parity even / odd
      par_en_i = 1'b1;
      send(8'h03, 8, 1, 1'b0, 1, 1, 0);
      check(!perr_o && rd_data_o == 8'h03, "R3 even parity ok", perr_o, 0);
      pop1();
      send(8'h03, 8, 1, 1'b1, 1, 1, 0);
      check(perr_o, "R3 even parity wrong", perr_o, 1);
      pop1();
      par_odd_i = 1'b1;
      send(8'h01, 8, 1, 1'b0, 1, 1, 0);
      check(perr_o, "R10 parity flag sticky", perr_o, 1);
      pop1();
      clear(4'b0010);
      check(!perr_o, "R10 parity clear", perr_o, 0);
      par_odd_i = 1'b0;
      par_en_i = 1'b0;

      // R4: marker bit
      mp_en_i = 1'b1;
      send(8'h31, 8, 1, 1'b1, 1, 1, 0);
      check(rd_mpb_o && rd_data_o == 8'h31, "R4 marker stored", rd_mpb_o, 1);
      pop1();
      par_en_i = 1'b1;
      send(8'h31, 8, 1, 1'b1, 1, 1, 0);
      check(!rd_mpb_o && !perr_o, "R4 parity wins over marker", rd_mpb_o, 0);
      pop1();
      par_en_i = 1'b0;
      mp_en_i = 1'b0;

      // R5: second stop bit low
      stop2_i = 1'b1;
      send(8'h44, 8, 0, 0, 1, 0, 1);
      check(ferr_o, "R5 framing error", ferr_o, 1);
      check(fill_o == 1 && rd_data_o == 8'h44, "R5 char kept", rd_data_o, 8'h44);
      pop1();
      clear(4'b0001);
      stop2_i = 1'b0;

      // R6: break
      hold(1'b0, BITCLK * 14);
      hold(1'b1, BITCLK * 2);
      check(brk_o && !ferr_o, "R6 break flagged", brk_o, 1);
      check(fill_o == 0, "R6 break stores nothing", fill_o, 0);
      send(8'h7E, 8, 0, 0, 1, 1, 0);
      check(rd_data_o == 8'h7E && fill_o == 1, "R6 recovery after break", rd_data_o, 8'h7E);
      pop1();
      clear(4'b1000);

      // R7/R8/R9: fill, overrun, drain
      for (int i = 0; i < DEPTH; i++) send(8'(i + 1), 8, 0, 0, 1, 1, 0);
      check(full_o && fill_o == 7'(DEPTH), "R8 full at depth", fill_o, DEPTH);
      send(8'hEE, 8, 0, 0, 1, 1, 0);
      check(orun_o, "R9 overrun flagged", orun_o, 1);
      check(fill_o == 7'(DEPTH) && rd_data_o == 8'h01, "R9 contents kept", rd_data_o, 1);
      for (int i = 0; i < DEPTH; i++) begin
         check(rd_data_o == 8'(i + 1), "R7 drain order", rd_data_o, i + 1);
         pop1();
      end
      check(fill_o == 0 && !ready_o, "R8 empty after drain", fill_o, 0);
      pop1();
      check(fill_o == 0, "R7 read on empty ignored", fill_o, 0);
      clear(4'b1111);
      check({brk_o, orun_o, perr_o, ferr_o} == 0, "R10 all clear",
            {brk_o, orun_o, perr_o, ferr_o}, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule